// File: doc/BRIEF.md
# Two-Phase Hardware Barrier

This block coordinates a group of processors at a barrier. Each processor port raises a one-cycle `arrive` pulse when it reaches the barrier and then waits for its `proceed` output. A single occupancy counter tracks the group through two phases:

- **Gathering.** Arrivals are added to the counter.
- **Draining.** Once the last expected participant has arrived, every waiting port is released. Each port then leaves by pulsing `leave`, and each leave takes one away from the counter.

The gathering phase only reopens once the counter is back at zero. A fast processor that reaches the next barrier while slower ones are still draining is therefore parked in a per-port pending flag and is counted after the reopening, never mixed into the barrier that is still in progress.

The group size comes from `cfg_parties`. It is sampled only while the unit is idle, meaning it is gathering and the counter is zero. Ports with an index at or above the group size do not take part. All pins are plain control signals: arrive and leave are single-cycle strobes and carry no handshake.

Top module: `barrier_sync`

## Requirements
- R1: After reset the counter is zero, `arrive_gate` is 1, `depart_gate` is 0 and every `proceed` bit is 0.
- R2: While fewer than n participants have been counted, no `proceed` bit is asserted and `arrive_gate` stays 1.
- R3: On the clock edge that samples the arrival which brings the count to n, `depart_gate` becomes 1, `arrive_gate` becomes 0, and `proceed` is set for all n participating ports, which are ports 0 to n-1.
- R4: Arrive pulses from several participating ports in the same cycle are all counted on that edge, and no increment is lost.
- R5: A port's `proceed` stays at 1 until that port pulses `leave`. A `leave` from a port whose `proceed` is 0 has no effect.
- R6: Each sampled `leave` from a released port clears that port's `proceed` and decrements the counter. `depart_gate` stays 1 while the count is above zero. The edge that samples the last leave sets `arrive_gate` to 1 and `depart_gate` to 0.
- R7: An arrive pulse taken during the draining phase, from a participant that has already left (this includes a leave and an arrive in the same cycle), is held pending. It is counted on the first edge after `arrive_gate` returns to 1, and it never releases the barrier that is still draining.
- R8: An arrive pulse is ignored in two cases: when it comes from a port whose index is n or above, and when it comes from a port that has already been counted and not yet left.
- R9: n is taken from `cfg_parties` only while the unit is idle. A value of 0, or one above NPORT, means NPORT. A change to `cfg_parties` during a barrier has no effect on that barrier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_parties | input | CW | Group size n (0 or above NPORT selects NPORT) |
| arrive | input | NPORT | Per-port one-cycle arrival strobe |
| leave | input | NPORT | Per-port one-cycle departure strobe |
| proceed | output | NPORT | Per-port release; held until that port leaves |
| arrive_gate | output | 1 | 1 while arrivals are being gathered |
| depart_gate | output | 1 | 1 while released ports are draining |

## Verification
The hardest situation to reach is a processor that re-arrives while the previous barrier is still draining. It must be parked without disturbing the count, and then counted exactly once after the reopening. The bench reaches it by pulsing `leave` and `arrive` together on one port while another participant is still released. It then checks three things:

- After the final leave, nothing is released.
- The parked arrival alone does not open the gate for a two-party group.
- For a one-party group, the parked arrival reopens the drain by itself one edge after the gate comes back.

Arrivals from ports that are not participating, repeated arrivals, and stray leaves are interleaved with a full sweep over every group size, using both one-at-a-time and simultaneous arrivals.

// File: rtl/barrier_pkg.sv
package barrier_pkg;

  typedef enum logic {
    PH_GATHER = 1'b0,
    PH_DRAIN  = 1'b1
  } phase_t;

  // Population count of a strobe vector (up to 32 ports).
  function automatic int unsigned ones32(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int k = 0; k < 32; k++) n += int'(v[k]);
    return n;
  endfunction

endpackage

// File: rtl/barrier_port.sv
module barrier_port (
  input  logic clk,
  input  logic rst_n,
  input  logic arrive,
  input  logic leave,
  input  logic member,
  input  logic gather_open,
  input  logic drain_open,
  output logic take,
  output logic drop,
  output logic proceed
);

  logic held_q;
  logic pend_q;

  assign take    = member & gather_open & ~held_q & (arrive | pend_q);
  assign drop    = held_q & drain_open & leave;
  assign proceed = held_q & drain_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      held_q <= (held_q & ~drop) | take;
      if (gather_open) pend_q <= 1'b0;
      else             pend_q <= pend_q | (member & arrive & (~held_q | drop));
    end
  end

  AST_HOLD_UNTIL_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (proceed && !leave) |=> proceed); // R5

  AST_PEND_NOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !held_q); // R7

endmodule

// File: rtl/barrier_ctrl.sv
module barrier_ctrl
  import barrier_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int CW    = $clog2(NPORT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    cfg_parties,
  input  logic [NPORT-1:0] take_vec,
  input  logic [NPORT-1:0] drop_vec,
  output logic [NPORT-1:0] member_vec,
  output logic             gather_open,
  output logic             drain_open
);

  localparam logic [CW-1:0] FULL = CW'(NPORT);

  phase_t        ph_q, ph_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [CW-1:0] lim_q, lim_cfg, lim_eff;
  logic [CW-1:0] n_take, n_drop;
  logic          idle;

  assign idle    = (ph_q == PH_GATHER) && (cnt_q == '0);
  assign lim_cfg = (cfg_parties == '0 || cfg_parties > FULL) ? FULL : cfg_parties;
  assign lim_eff = idle ? lim_cfg : lim_q;
  assign n_take  = CW'(ones32(32'(take_vec)));
  assign n_drop  = CW'(ones32(32'(drop_vec)));

  for (genvar i = 0; i < NPORT; i++) begin : g_member
    assign member_vec[i] = (CW'(i) < lim_eff);
  end

  always_comb begin
    ph_n  = ph_q;
    cnt_n = cnt_q;
    if (ph_q == PH_GATHER) begin
      cnt_n = cnt_q + n_take;
      if (cnt_n == lim_eff) ph_n = PH_DRAIN;
    end else begin
      cnt_n = cnt_q - n_drop;
      if (cnt_n == '0) ph_n = PH_GATHER;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_GATHER;
      cnt_q <= '0;
      lim_q <= FULL;
    end else begin
      ph_q  <= ph_n;
      cnt_q <= cnt_n;
      if (idle) lim_q <= lim_cfg;
    end
  end

  assign gather_open = (ph_q == PH_GATHER);
  assign drain_open  = (ph_q == PH_DRAIN);

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim_q); // R2

  AST_FULL_ON_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drain_open) |-> (cnt_q == lim_q)); // R3

  AST_EMPTY_ON_GATHER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gather_open) |-> (cnt_q == '0)); // R6

  AST_NO_TAKE_IN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    drain_open |-> (take_vec == '0)); // R7

  AST_LIMIT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && $past(!idle)) |-> $stable(lim_q)); // R9

endmodule

// File: rtl/barrier_sync.sv
module barrier_sync #(
  parameter int NPORT = 4,
  parameter int CW    = $clog2(NPORT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    cfg_parties,
  input  logic [NPORT-1:0] arrive,
  input  logic [NPORT-1:0] leave,
  output logic [NPORT-1:0] proceed,
  output logic             arrive_gate,
  output logic             depart_gate
);

  logic [NPORT-1:0] take_vec;
  logic [NPORT-1:0] drop_vec;
  logic [NPORT-1:0] member_vec;
  logic             gather_open;
  logic             drain_open;

  barrier_ctrl #(.NPORT(NPORT), .CW(CW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_parties (cfg_parties),
    .take_vec    (take_vec),
    .drop_vec    (drop_vec),
    .member_vec  (member_vec),
    .gather_open (gather_open),
    .drain_open  (drain_open)
  );

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    barrier_port u_port (
      .clk         (clk),
      .rst_n       (rst_n),
      .arrive      (arrive[i]),
      .leave       (leave[i]),
      .member      (member_vec[i]),
      .gather_open (gather_open),
      .drain_open  (drain_open),
      .take        (take_vec[i]),
      .drop        (drop_vec[i]),
      .proceed     (proceed[i])
    );
  end

  assign arrive_gate = gather_open;
  assign depart_gate = drain_open;

  AST_GATES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    arrive_gate != depart_gate); // R1

  AST_NO_EARLY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    arrive_gate |-> (proceed == '0)); // R2

endmodule

// File: tb/test_barrier_sync.sv
module test_barrier_sync;

  localparam int NPORT = 4;
  localparam int CW    = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CW-1:0]    cfg_parties = '0;
  logic [NPORT-1:0] arrive = '0;
  logic [NPORT-1:0] leave = '0;
  logic [NPORT-1:0] proceed;
  logic             arrive_gate;
  logic             depart_gate;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;

  barrier_sync #(.NPORT(NPORT), .CW(CW)) i_barrier_sync (
    .clk(clk), .rst_n(rst_n), .cfg_parties(cfg_parties),
    .arrive(arrive), .leave(leave), .proceed(proceed),
    .arrive_gate(arrive_gate), .depart_gate(depart_gate)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {arrive_gate, depart_gate, proceed}
  function automatic int obs();
    return {26'd0, arrive_gate, depart_gate, proceed};
  endfunction

  function automatic int want(input bit ag, input logic [3:0] pr);
    return {26'd0, ag, ~ag, pr};
  endfunction

  task automatic drive(input logic [3:0] a, input logic [3:0] l);
    arrive = a;
    leave  = l;
    @(negedge clk);
    arrive = '0;
    leave  = '0;
  endtask

  initial begin
    #(20 * 100000);
    n_fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset state", obs(), want(1'b1, 4'h0));

    // Sweep every group size, sequential and simultaneous arrivals
    for (int n = 1; n <= NPORT; n++) begin
      for (int simul = 0; simul < 2; simul++) begin
        logic [3:0] mask;
        logic [3:0] rem;
        mask = 4'((1 << n) - 1);
        cfg_parties = CW'(n);
        if (n < NPORT) begin
          drive(~mask, 4'h0);
          chk("R8 non-member arrive", obs(), want(1'b1, 4'h0));
        end
        if (simul == 1) begin
          drive(mask, 4'h0);
          chk("R4 simultaneous arrivals", obs(), want(1'b0, mask));
        end else begin
          for (int p = 0; p < n; p++) begin
            drive(4'(1 << p), 4'h0);
            if (p < n - 1) begin
              chk("R2 partial arrivals", obs(), want(1'b1, 4'h0));
              drive(4'(1 << p), 4'h0);
              chk("R8 repeated arrive", obs(), want(1'b1, 4'h0));
            end else begin
              chk("R3 last arrival releases", obs(), want(1'b0, mask));
            end
          end
        end
        drive(4'h0, 4'h0);
        drive(4'h0, ~mask);
        chk("R5 release held", obs(), want(1'b0, mask));
        rem = mask;
        for (int p = n - 1; p >= 0; p--) begin
          drive(4'h0, 4'(1 << p));
          rem[p] = 1'b0;
          if (rem != 0) chk("R6 partial drain", obs(), want(1'b0, rem));
          else          chk("R6 drain complete", obs(), want(1'b1, 4'h0));
        end
      end
    end

    // R5: leave while not released is ignored
    cfg_parties = 3'd2;
    drive(4'h1, 4'h0);
    drive(4'h0, 4'h1);
    drive(4'h2, 4'h0);
    chk("R5 stray leave ignored", obs(), want(1'b0, 4'h3));
    drive(4'h0, 4'h3);
    chk("R6 both leave", obs(), want(1'b1, 4'h0));

    // R9: mid-barrier cfg change ignored
    drive(4'h1, 4'h0);
    cfg_parties = 3'd3;
    drive(4'h2, 4'h0);
    chk("R9 cfg change ignored", obs(), want(1'b0, 4'h3));
    drive(4'h0, 4'h3);

    // R9: zero means all ports
    cfg_parties = 3'd0;
    drive(4'h7, 4'h0);
    chk("R9 zero means full", obs(), want(1'b1, 4'h0));
    drive(4'h8, 4'h0);
    chk("R9 zero means full release", obs(), want(1'b0, 4'hF));
    drive(4'h0, 4'hF);

    // R7: early re-arrival held pending (two parties)
    cfg_parties = 3'd2;
    drive(4'h3, 4'h0);
    drive(4'h1, 4'h1);
    chk("R7 leave+arrive same cycle", obs(), want(1'b0, 4'h2));
    drive(4'h0, 4'h2);
    chk("R7 reopen no release", obs(), want(1'b1, 4'h0));
    drive(4'h0, 4'h0);
    chk("R7 pending alone insufficient", obs(), want(1'b1, 4'h0));
    drive(4'h2, 4'h0);
    chk("R7 pending counted once", obs(), want(1'b0, 4'h3));
    drive(4'h0, 4'h3);

    // R7: single party re-arrival re-releases after reopen
    cfg_parties = 3'd1;
    drive(4'h1, 4'h0);
    drive(4'h1, 4'h1);
    chk("R7 reopen after last leave", obs(), want(1'b1, 4'h0));
    drive(4'h0, 4'h0);
    chk("R7 pending releases next edge", obs(), want(1'b0, 4'h1));
    drive(4'h0, 4'h1);

    // R8: arrive from held port not recorded
    drive(4'h1, 4'h0);
    drive(4'h1, 4'h0);
    drive(4'h0, 4'h1);
    chk("R8 held arrive ignored a", obs(), want(1'b1, 4'h0));
    drive(4'h0, 4'h0);
    chk("R8 held arrive ignored b", obs(), want(1'b1, 4'h0));

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule